// File: doc/BRIEF.md
# Conditional-Access Card Slot Bridge

This block lets a host reach two removable conditional-access card slots through a small register window. The host latches a card address in two registers and programs a control byte. That byte picks the slot, picks the card space (attribute memory or control/IO), requests per-slot card resets and turns on the transport stream path through each slot. An access to the data register then runs one card bus cycle at the latched address. The cycle asserts the proper strobe for a fixed number of clocks and latches the card's read data at the end.

Reset requests are handshakes the host polls. Setting a request bit drives the slot's reset line high for a programmable time, waits a further settle time, and then clears the bit by itself. A status register shows the card-detect inputs. A second control byte enables the two stream outputs and drives two active-low tuner reset lines.

The host port is a single-cycle request with an acknowledge. A register access is acknowledged one clock after the request. A data access is acknowledged when its card cycle ends. Requests made while a card cycle is running are dropped.

Top module: `ci_slot_bridge`

## Requirements
- R1: Offset 0 (address low) stores bits [7:1] and reads bit 0 as 0. Offset 1 (address high) stores bits [6:0] and reads bit 7 as 0. `card_a` always equals {high[6:0], low[7:1]}, so the low register's bit 1 lands on card address bit 0.
- R2: Offset 2 is the bus control byte. Bit 7 selects the slot (0 or 1). Bit 6 selects the space: 0 for attribute memory, 1 for control/IO. During a card cycle only the selected slot has one strobe low. In attribute space that is `card_oe_n` for a read and `card_we_n` for a write. In control/IO space it is `card_iord_n` for a read and `card_iowr_n` for a write.
- R3: A request to offset 3 (data) starts a card cycle. `host_busy` and the strobe are active for exactly STROBE_LEN clocks. On a write, `card_d_out` holds the written byte and `card_d_oe` is high for that time. `host_ack` rises in the clock after the last strobe clock. On a read, `host_rdata` then shows `card_d_in` as sampled on the last strobe clock.
- R4: Writing 1 to control bit (5 − n) while slot n has no reset pending starts a reset. `card_rst[n]` is high for RST_HOLD clocks. The bit then stays 1 for RST_SETTLE more clocks and clears itself. Writing 0 to the bit during a reset has no effect.
- R5: Control bit (3 − n) drives `ts_en[n]`. Control bits 1:0 are plain read/write storage.
- R6: Offset 4 (status) reads `card_det_n[1]` in bit 0 and `card_det_n[0]` in bit 1, with all other bits 0. A low bit means the card in that slot is present and ready.
- R7: Offset 5 is the second control byte, fully read/write. Bit 4 drives `stream_out_en[0]` and bit 5 drives `stream_out_en[1]`. Bit 3 drives `tuner_rst_n[0]` and bit 2 drives `tuner_rst_n[1]`. Its reset value is 0x0C, so both tuners start out of reset.
- R8: A request to offsets 0, 1, 2, 4, 5, 6 or 7 is acknowledged one clock later. Read data is valid with `host_ack`, and `host_rdata` is 0 in every other clock. A request made while `host_busy` is high gets no acknowledge and changes no state.
- R9: After reset, all registers are 0 except the second control byte. No strobe is low, no reset line is high, `host_busy` and `host_ack` are low, and `card_a` is 0.
- R10: Offsets 6 and 7 read as 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Single-cycle access request |
| host_we | input | 1 | 1 = write, 0 = read |
| host_sel | input | 3 | Register offset |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, valid with host_ack |
| host_ack | output | 1 | Access complete |
| host_busy | output | 1 | Card cycle in progress |
| card_a | output | 14 | Card address |
| card_d_out | output | 8 | Card write data |
| card_d_oe | output | 1 | Card data drive enable |
| card_d_in | input | 8 | Card read data |
| card_oe_n | output | 2 | Attribute read strobe per slot |
| card_we_n | output | 2 | Attribute write strobe per slot |
| card_iord_n | output | 2 | Control/IO read strobe per slot |
| card_iowr_n | output | 2 | Control/IO write strobe per slot |
| card_rst | output | 2 | Card reset per slot, active high |
| card_det_n | input | 2 | Card present and ready per slot, active low |
| ts_en | output | 2 | Transport stream path enable per slot |
| stream_out_en | output | 2 | Stream output enables |
| tuner_rst_n | output | 2 | Tuner reset lines, active low |

## Verification
The bench builds the block with STROBE_LEN = 3, RST_HOLD = 5 and RST_SETTLE = 4. The default hold and settle counts stand for real milliseconds and are far too long to reach. With these short values a full reset handshake, the host polling the self-clearing bit, and a zero written in the middle of a reset all fit in a few dozen clocks. A three-clock strobe also leaves room to aim a second request into the middle of a card cycle. This shows that such requests are dropped, and lets the bench check the exact clock of the acknowledge and the read-data sample against the behavioural model.

// File: rtl/ci_slot_bridge.sv
module ci_slot_bridge #(
  parameter int STROBE_LEN = 8,
  parameter int RST_HOLD   = 100000,
  parameter int RST_SETTLE = 50000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_req,
  input  logic        host_we,
  input  logic [2:0]  host_sel,
  input  logic [7:0]  host_wdata,
  output logic [7:0]  host_rdata,
  output logic        host_ack,
  output logic        host_busy,
  output logic [13:0] card_a,
  output logic [7:0]  card_d_out,
  output logic        card_d_oe,
  input  logic [7:0]  card_d_in,
  output logic [1:0]  card_oe_n,
  output logic [1:0]  card_we_n,
  output logic [1:0]  card_iord_n,
  output logic [1:0]  card_iowr_n,
  output logic [1:0]  card_rst,
  input  logic [1:0]  card_det_n,
  output logic [1:0]  ts_en,
  output logic [1:0]  stream_out_en,
  output logic [1:0]  tuner_rst_n
);

  localparam logic [2:0] SEL_ALO   = 3'd0;
  localparam logic [2:0] SEL_AHI   = 3'd1;
  localparam logic [2:0] SEL_CTRL  = 3'd2;
  localparam logic [2:0] SEL_DATA  = 3'd3;
  localparam logic [2:0] SEL_STAT  = 3'd4;
  localparam logic [2:0] SEL_CTRL2 = 3'd5;
  localparam int RMAX = (RST_HOLD > RST_SETTLE) ? RST_HOLD : RST_SETTLE;
  localparam int RCW  = $clog2(RMAX + 1);
  localparam int SCW  = $clog2(STROBE_LEN + 1);
  localparam logic [RCW-1:0] HOLD_LAST   = RCW'(RST_HOLD - 1);
  localparam logic [RCW-1:0] SETTLE_LAST = RCW'(RST_SETTLE - 1);
  localparam logic [SCW-1:0] STB_LAST    = SCW'(STROBE_LEN - 1);

  logic [6:0]     addr_lo, addr_hi;
  logic           slot_sel, space_io;
  logic [1:0]     ts_bits, spare;
  logic [7:0]     ctrl2;
  logic [1:0]     rst_req, rst_hold;
  logic [RCW-1:0] rst_cnt [2];
  logic           cyc_on, cyc_we;
  logic [SCW-1:0] cyc_cnt;
  logic [7:0]     wr_byte;

  wire take     = host_req && !cyc_on;
  wire reg_wr   = take && host_we;
  wire ctrl_wr  = reg_wr && host_sel == SEL_CTRL;
  wire cyc_done = cyc_on && cyc_cnt == STB_LAST;

  assign host_busy     = cyc_on;
  assign card_a        = {addr_hi, addr_lo};
  assign card_d_out    = wr_byte;
  assign card_d_oe     = cyc_on && cyc_we;
  assign card_rst      = rst_hold;
  assign stream_out_en = ctrl2[5:4];
  assign tuner_rst_n   = {ctrl2[2], ctrl2[3]};

  genvar n;
  generate
    for (n = 0; n < 2; n++) begin : g_slot
      wire hit = cyc_on && (slot_sel == 1'(n));
      assign card_oe_n[n]   = !(hit && !space_io && !cyc_we);
      assign card_we_n[n]   = !(hit && !space_io &&  cyc_we);
      assign card_iord_n[n] = !(hit &&  space_io && !cyc_we);
      assign card_iowr_n[n] = !(hit &&  space_io &&  cyc_we);
      assign ts_en[n]       = ts_bits[n];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          rst_req[n]  <= 1'b0;
          rst_hold[n] <= 1'b0;
          rst_cnt[n]  <= '0;
        end else if (!rst_req[n]) begin
          if (ctrl_wr && host_wdata[5-n]) begin
            rst_req[n]  <= 1'b1;
            rst_hold[n] <= 1'b1;
            rst_cnt[n]  <= '0;
          end
        end else if (rst_hold[n]) begin
          if (rst_cnt[n] == HOLD_LAST) begin
            rst_hold[n] <= 1'b0;
            rst_cnt[n]  <= '0;
          end else begin
            rst_cnt[n] <= rst_cnt[n] + 1'b1;
          end
        end else if (rst_cnt[n] == SETTLE_LAST) begin
          rst_req[n] <= 1'b0;
        end else begin
          rst_cnt[n] <= rst_cnt[n] + 1'b1;
        end
      end

      assert_hold_then_settle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(card_rst[n]) |-> rst_req[n]);
      assert_clear_after_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_req[n]) |-> !card_rst[n] && $past(!card_rst[n]));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_lo  <= '0;
      addr_hi  <= '0;
      slot_sel <= 1'b0;
      space_io <= 1'b0;
      ts_bits  <= '0;
      spare    <= '0;
      ctrl2    <= 8'h0C;
    end else if (reg_wr) begin
      case (host_sel)
        SEL_ALO:   addr_lo <= host_wdata[7:1];
        SEL_AHI:   addr_hi <= host_wdata[6:0];
        SEL_CTRL: begin
          slot_sel <= host_wdata[7];
          space_io <= host_wdata[6];
          ts_bits  <= {host_wdata[2], host_wdata[3]};
          spare    <= host_wdata[1:0];
        end
        SEL_CTRL2: ctrl2 <= host_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_on     <= 1'b0;
      cyc_we     <= 1'b0;
      cyc_cnt    <= '0;
      wr_byte    <= '0;
      host_ack   <= 1'b0;
      host_rdata <= '0;
    end else begin
      host_ack   <= 1'b0;
      host_rdata <= '0;
      if (cyc_on) begin
        if (cyc_done) begin
          cyc_on   <= 1'b0;
          host_ack <= 1'b1;
          if (!cyc_we) host_rdata <= card_d_in;
        end else begin
          cyc_cnt <= cyc_cnt + 1'b1;
        end
      end else if (take) begin
        if (host_sel == SEL_DATA) begin
          cyc_on  <= 1'b1;
          cyc_we  <= host_we;
          cyc_cnt <= '0;
          if (host_we) wr_byte <= host_wdata;
        end else begin
          host_ack <= 1'b1;
          if (!host_we) begin
            case (host_sel)
              SEL_ALO:   host_rdata <= {addr_lo, 1'b0};
              SEL_AHI:   host_rdata <= {1'b0, addr_hi};
              SEL_CTRL:  host_rdata <= {slot_sel, space_io, rst_req[0], rst_req[1],
                                        ts_bits[0], ts_bits[1], spare};
              SEL_STAT:  host_rdata <= {6'b0, card_det_n[0], card_det_n[1]};
              SEL_CTRL2: host_rdata <= ctrl2;
              default:   host_rdata <= '0;
            endcase
          end
        end
      end
    end
  end

  assert_cycle_end_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(host_busy) |-> host_ack);
  assert_addr_steady_R1: assert property (@(posedge clk) disable iff (!rst_n)
    host_busy && $past(host_busy) |-> $stable(card_a));
  assert_tuner_by_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tuner_rst_n) |-> $past(host_req && host_we && !host_busy && host_sel == SEL_CTRL2));
  assert_strobe_only_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(&{card_oe_n, card_we_n, card_iord_n, card_iowr_n}) |-> host_busy || $past(host_busy));

endmodule

// File: tb/sim_ci_slot_bridge.sv
module sim_ci_slot_bridge;
  localparam int SL = 3, RH = 5, RS = 4;

  logic clk = 0, rst_n = 0;
  logic host_req = 0, host_we = 0;
  logic [2:0] host_sel = 0;
  logic [7:0] host_wdata = 0, card_d_in = 0;
  logic [1:0] card_det_n = 2'b11;
  logic [7:0] host_rdata, card_d_out;
  logic host_ack, host_busy, card_d_oe;
  logic [13:0] card_a;
  logic [1:0] card_oe_n, card_we_n, card_iord_n, card_iowr_n, card_rst, ts_en, stream_out_en, tuner_rst_n;

  ci_slot_bridge #(.STROBE_LEN(SL), .RST_HOLD(RH), .RST_SETTLE(RS)) u0 (.*);

  always #4 clk = ~clk;

  int vectors = 0, fails = 0, cycles = 0;

  // behavioural model
  int m_lo, m_hi, m_slot, m_space, m_ts0, m_ts1, m_spare, m_c2;
  int m_req[2], m_hold[2], m_cnt[2];
  int m_busy, m_ccnt, m_cwe, m_wd, m_ack, m_rd;

  task automatic model_reset();
    m_lo = 0; m_hi = 0; m_slot = 0; m_space = 0; m_ts0 = 0; m_ts1 = 0; m_spare = 0; m_c2 = 8'h0C;
    for (int i = 0; i < 2; i++) begin m_req[i] = 0; m_hold[i] = 0; m_cnt[i] = 0; end
    m_busy = 0; m_ccnt = 0; m_cwe = 0; m_wd = 0; m_ack = 0; m_rd = 0;
  endtask

  initial model_reset();

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else begin
      int take, wd, cw, cur_req0, cur_req1, busy0;
      take = host_req && !m_busy;
      wd = host_wdata;
      cw = take && host_we && host_sel == 2;
      cur_req0 = m_req[0]; cur_req1 = m_req[1];
      busy0 = m_busy;
      for (int i = 0; i < 2; i++) begin
        if (!m_req[i]) begin
          if (cw && wd[5-i]) begin m_req[i] = 1; m_hold[i] = 1; m_cnt[i] = 0; end
        end else if (m_hold[i]) begin
          if (m_cnt[i] == RH - 1) begin m_hold[i] = 0; m_cnt[i] = 0; end else m_cnt[i]++;
        end else if (m_cnt[i] == RS - 1) m_req[i] = 0;
        else m_cnt[i]++;
      end
      m_ack = 0; m_rd = 0;
      if (busy0) begin
        if (m_ccnt == SL - 1) begin
          m_busy = 0; m_ack = 1;
          if (!m_cwe) m_rd = card_d_in;
        end else m_ccnt++;
      end else if (take) begin
        if (host_sel == 3) begin
          m_busy = 1; m_cwe = host_we; m_ccnt = 0;
          if (host_we) m_wd = wd;
        end else begin
          m_ack = 1;
          if (!host_we) begin
            case (host_sel)
              0: m_rd = m_lo << 1;
              1: m_rd = m_hi;
              2: m_rd = (m_slot << 7) | (m_space << 6) | (cur_req0 << 5) | (cur_req1 << 4) |
                        (m_ts0 << 3) | (m_ts1 << 2) | m_spare;
              4: m_rd = (card_det_n[0] << 1) | card_det_n[1];
              5: m_rd = m_c2;
              default: m_rd = 0;
            endcase
          end else begin
            case (host_sel)
              0: m_lo = (wd >> 1) & 8'h7F;
              1: m_hi = wd & 8'h7F;
              2: begin
                m_slot = wd[7]; m_space = wd[6]; m_ts0 = wd[3]; m_ts1 = wd[2]; m_spare = wd & 3;
              end
              5: m_c2 = wd;
              default: ;
            endcase
          end
        end
      end
    end
  end

  task automatic cmp(input string tag, input string what, input int act, input int exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at cycle %0d", tag, what, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      int st;
      cmp("R1", "card_a", card_a, (m_hi << 7) | m_lo);
      for (int i = 0; i < 2; i++) begin
        int hit;
        hit = m_busy && m_slot == i;
        st = {!(hit && !m_space && !m_cwe), !(hit && !m_space && m_cwe),
              !(hit && m_space && !m_cwe), !(hit && m_space && m_cwe)};
        cmp("R2", "strobes", {card_oe_n[i], card_we_n[i], card_iord_n[i], card_iowr_n[i]}, st);
        cmp("R4", "card_rst", card_rst[i], m_req[i] && m_hold[i]);
      end
      cmp("R3", "busy", host_busy, m_busy);
      cmp("R3", "d_oe", card_d_oe, m_busy && m_cwe);
      cmp("R3", "d_out", card_d_out, m_wd);
      cmp("R8", "ack", host_ack, m_ack);
      cmp("R8", "rdata", host_rdata, m_rd);
      cmp("R5", "ts_en", ts_en, {m_ts1[0], m_ts0[0]});
      cmp("R7", "stream", stream_out_en, (m_c2 >> 4) & 3);
      cmp("R7", "tuner", tuner_rst_n, {m_c2[2], m_c2[3]});
    end
    if (cycles > 20000) begin
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  logic [7:0] got;

  task automatic acc(input logic [2:0] sel, input logic we, input logic [7:0] wd);
    int w;
    @(negedge clk);
    host_req = 1; host_we = we; host_sel = sel; host_wdata = wd;
    @(negedge clk);
    host_req = 0;
    w = 0;
    while (!host_ack && w < 50) begin @(negedge clk); w++; end
    got = host_rdata;
  endtask

  task automatic expect_rd(input string tag, input logic [2:0] sel, input logic [7:0] exp);
    acc(sel, 0, 0);
    cmp(tag, "readback", got, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    cmp("R9", "reset busy", host_busy, 0);
    cmp("R9", "reset rst", card_rst, 0);
    rst_n = 1;
    expect_rd("R9", 2, 8'h00);
    expect_rd("R9", 5, 8'h0C);
    cmp("R7", "tuner out of reset", tuner_rst_n, 2'b11);

    acc(0, 1, 8'hFF); acc(1, 1, 8'hAB);
    expect_rd("R1", 0, 8'hFE);
    expect_rd("R1", 1, 8'h2B);
    cmp("R1", "addr", card_a, 14'h15FF);
    acc(0, 1, 8'h02);
    cmp("R1", "addr bit0", card_a[6:0], 7'h01);

    card_d_in = 8'h5A;
    acc(2, 1, 8'h00); acc(3, 0, 0);
    cmp("R3", "attr read slot0", got, 8'h5A);
    acc(2, 1, 8'hC0); acc(3, 1, 8'h33);
    acc(2, 1, 8'h40); card_d_in = 8'hA7; acc(3, 0, 0);
    cmp("R3", "io read slot0", got, 8'hA7);
    acc(2, 1, 8'h80); acc(3, 1, 8'h96);

    // request during busy is dropped
    @(negedge clk); host_req = 1; host_we = 0; host_sel = 3;
    @(negedge clk); host_sel = 0; host_we = 1; host_wdata = 8'h7E;
    @(negedge clk); host_req = 0;
    repeat (4) @(negedge clk);
    expect_rd("R8", 0, 8'h02);

    // reset slot 0, write 0 midway
    acc(2, 1, 8'h20);
    expect_rd("R4", 2, 8'h20);
    acc(2, 1, 8'h00);
    expect_rd("R4", 2, 8'h20);
    repeat (10) @(negedge clk);
    expect_rd("R4", 2, 8'h00);

    // reset slot 1 with ts enables
    acc(2, 1, 8'h1F);
    expect_rd("R5", 2, 8'h1F);
    cmp("R5", "ts_en", ts_en, 2'b11);
    repeat (12) @(negedge clk);
    expect_rd("R4", 2, 8'h0F);
    acc(2, 1, 8'h08);
    cmp("R5", "ts slot0 only", ts_en, 2'b01);

    card_det_n = 2'b01;
    expect_rd("R6", 4, 8'h02);
    card_det_n = 2'b10;
    expect_rd("R6", 4, 8'h01);

    acc(5, 1, 8'h30);
    cmp("R7", "stream", stream_out_en, 2'b11);
    cmp("R7", "tuner", tuner_rst_n, 2'b00);
    acc(5, 1, 8'h18);
    cmp("R7", "stream", stream_out_en, 2'b01);
    cmp("R7", "tuner", tuner_rst_n, 2'b01);

    acc(6, 1, 8'hFF);
    expect_rd("R10", 6, 8'h00);
    expect_rd("R10", 7, 8'h00);
    expect_rd("R10", 0, 8'h02);
    expect_rd("R10", 5, 8'h18);

    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule